// File: doc/BRIEF.md
# Successive-Approximation Scan Controller

This block is the digital side of a successive-approximation converter that serves several analog inputs. When a start request is accepted, it picks a channel, pulses a sample strobe with the channel index on the multiplexer select, and then runs a binary search. The search uses one compare cycle per result bit. Each cycle it presents a trial code to an external DAC and reads back one comparator bit, which says whether the held input is at or above that trial code. The analog multiplexer, the hold stage, the DAC and the comparator are outside the block.

Two ways of picking the channel exist. In scan mode each start converts the next channel enabled in a channel mask, in rising index order, wrapping back to the lowest enabled channel. In single mode the addressed channel is converted whatever the mask holds. Each result is announced with a one-cycle done pulse and also leaves through an SPI-like serial port: a select line, a shift clock and a data line. The frame carries the channel tag followed by the data word.

Top module: `sar_scan_ctrl`

## Requirements
- R1: During compare cycle k (k = 0 first) of an N-bit conversion, `dac_code` has bit N-1-k set, the bits above it equal the bits already decided, and the bits below it are zero. Outside compare cycles `dac_code` is 0.
- R2: A trial bit is kept when `cmp_hi` is 1 (input at or above the trial code) and cleared when it is 0. With an ideal comparator the result equals the input code, and inputs beyond full scale give 2^N-1, so codes 0 to 2^N-1 are all reachable.
- R3: An accepted start makes `sample` high for exactly the next cycle, followed by N compare cycles. `done` is high for one cycle, the (N+2)th cycle after acceptance. `result` and `result_ch` change only in that cycle and hold until the next `done`.
- R4: In scan mode (`single_mode`=0) the converted channel is the lowest enabled channel (bit i of `ch_mask` = 1 enables channel i) whose index is above the last scanned channel. If there is none, it is the lowest enabled channel. After reset the lowest enabled channel is taken first.
- R5: In single mode the channel `single_ch` is converted regardless of `ch_mask`, and the scan position is left unchanged.
- R6: The serial frame starts in the cycle `done` is high. `ser_cs_n` is low for 2*(3+N) cycles. Each bit is held for two cycles, with `ser_sck` low in the first cycle and high in the second. The 3-bit channel tag comes first, MSB first, then the result, MSB first. Outside a frame `ser_sck` and `ser_sdo` are 0.
- R7: `busy` is high from the cycle after acceptance until the cycle after `ser_cs_n` returns high. A start seen while `busy` is high has no effect.
- R8: In scan mode a start with `ch_mask` all zero is not accepted and `busy` stays low.
- R9: After reset `busy`, `sample`, `done`, `ser_sck` and `ser_sdo` are 0, `ser_cs_n` is 1, and `dac_code`, `result` and `result_ch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, seen only while idle |
| single_mode | input | 1 | 1: convert `single_ch`; 0: scan the enabled channels |
| single_ch | input | 3 | Addressed channel for single mode |
| ch_mask | input | 8 | Channel enables for scan mode |
| cmp_hi | input | 1 | Comparator: 1 when held input is at or above `dac_code` |
| mux_sel | output | 3 | Channel under conversion |
| sample | output | 1 | One-cycle strobe telling the hold stage to capture |
| dac_code | output | 12 | Trial code for the external DAC |
| busy | output | 1 | Conversion or frame in progress |
| done | output | 1 | One-cycle pulse: new result valid |
| result | output | 12 | Last converted code |
| result_ch | output | 3 | Channel of the last converted code |
| ser_cs_n | output | 1 | Serial frame select, active low |
| ser_sck | output | 1 | Serial shift clock |
| ser_sdo | output | 1 | Serial data, valid on rising `ser_sck` |

## Verification
The hardest cases to reach from the ports are the state that is kept between conversions, and a start that lands in the middle of one. The scan position is never visible directly. The stimulus shows it by running scan conversions, then a single-mode conversion, then more scan conversions over a sparse mask, so that both a skipped channel and a wrap show up in `result_ch`. A second start is pulsed with a different address in the middle of a conversion, and the following channel tag and idle period show that it was dropped. Full-scale, zero and over-range inputs reach the two ends of the code range.

// File: rtl/sar_scan_pkg.sv
package sar_scan_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAMP = 2'd1,
        PH_CONV = 2'd2,
        PH_SEND = 2'd3
    } scan_phase_e;
endpackage

// File: rtl/sar_chan_pick.sv
module sar_chan_pick #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CH_W-1:0]   last,
    output logic [CH_W-1:0]   pick,
    output logic              any
);
    logic [CH_W-1:0] above;
    logic [CH_W-1:0] lowest;
    logic            above_hit;

    always_comb begin
        above     = '0;
        lowest    = '0;
        above_hit = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                lowest = CH_W'(i);
                if (i > int'(last)) begin
                    above     = CH_W'(i);
                    above_hit = 1'b1;
                end
            end
        end
        pick = above_hit ? above : lowest;
        any  = |mask;
    end
endmodule

// File: rtl/sar_bitsearch.sv
module sar_bitsearch #(
    parameter int RES_W = 12,
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] decided,
    output logic             last
);
    typedef struct packed {
        logic [RES_W-1:0] code;
        logic [IDX_W-1:0] idx;
    } srch_t;

    srch_t r_q, r_d;

    always_comb begin
        trial   = r_q.code | (RES_W'(1) << r_q.idx);
        last    = (r_q.idx == '0);
        decided = cmp_hi ? trial : r_q.code;
        r_d     = r_q;
        if (init) begin
            r_d.code = '0;
            r_d.idx  = IDX_W'(RES_W - 1);
        end else if (step) begin
            r_d.code = decided;
            if (r_q.idx != '0) r_d.idx = r_q.idx - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (trial == (RES_W'(1) << (RES_W - 1))));
    p_keep_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cmp_hi) |=> (r_q.code == $past(trial)));
    p_below_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cmp_hi) |=> (r_q.code < $past(trial)));
endmodule

// File: rtl/sar_frame_tx.sv
module sar_frame_tx #(
    parameter int FRAME_W = 15,
    localparam int CNT_W = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] word,
    output logic               active,
    output logic               cs_n,
    output logic               sck,
    output logic               sdo
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   left;
        logic               ph;
        logic               act;
    } tx_t;

    tx_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.sh   = word;
            t_d.left = CNT_W'(FRAME_W);
            t_d.ph   = 1'b0;
            t_d.act  = 1'b1;
        end else if (t_q.act) begin
            t_d.ph = ~t_q.ph;
            if (t_q.ph) begin
                t_d.sh   = t_q.sh << 1;
                t_d.left = t_q.left - 1'b1;
                if (t_q.left == CNT_W'(1)) t_d.act = 1'b0;
            end
        end
        active = t_q.act;
        cs_n   = ~t_q.act;
        sck    = t_q.act & t_q.ph;
        sdo    = t_q.act & t_q.sh[FRAME_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    p_sck_alternates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.act && $past(t_q.act)) |-> (sck != $past(sck)));
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !t_q.act);
endmodule

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl #(
    parameter int RES_W  = 12,
    parameter int NUM_CH = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int FRAME_W = CH_W + RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              single_mode,
    input  logic [CH_W-1:0]   single_ch,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic              cmp_hi,
    output logic [CH_W-1:0]   mux_sel,
    output logic              sample,
    output logic [RES_W-1:0]  dac_code,
    output logic              busy,
    output logic              done,
    output logic [RES_W-1:0]  result,
    output logic [CH_W-1:0]   result_ch,
    output logic              ser_cs_n,
    output logic              ser_sck,
    output logic              ser_sdo
);
    import sar_scan_pkg::*;

    typedef struct packed {
        scan_phase_e     st;
        logic [CH_W-1:0] ch;
        logic [CH_W-1:0] ptr;
        logic            done;
        logic [RES_W-1:0] res;
        logic [CH_W-1:0] res_ch;
    } ctl_t;

    ctl_t c_q, c_d;

    logic [CH_W-1:0]  pick;
    logic             pick_any;
    logic [RES_W-1:0] trial;
    logic [RES_W-1:0] decided;
    logic             last_bit;
    logic             accept;
    logic             step;
    logic             load;
    logic             tx_active;

    sar_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) pick_i (
        .mask (ch_mask),
        .last (c_q.ptr),
        .pick (pick),
        .any  (pick_any)
    );

    sar_bitsearch #(.RES_W(RES_W)) srch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (accept),
        .step    (step),
        .cmp_hi  (cmp_hi),
        .trial   (trial),
        .decided (decided),
        .last    (last_bit)
    );

    sar_frame_tx #(.FRAME_W(FRAME_W)) tx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .word   ({c_q.ch, decided}),
        .active (tx_active),
        .cs_n   (ser_cs_n),
        .sck    (ser_sck),
        .sdo    (ser_sdo)
    );

    always_comb begin
        accept = (c_q.st == PH_IDLE) && start && (single_mode || pick_any);
        step   = (c_q.st == PH_CONV);
        load   = step && last_bit;
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.st)
            PH_IDLE: if (accept) begin
                c_d.st = PH_SAMP;
                if (single_mode) begin
                    c_d.ch = single_ch;
                end else begin
                    c_d.ch  = pick;
                    c_d.ptr = pick;
                end
            end
            PH_SAMP: c_d.st = PH_CONV;
            PH_CONV: if (last_bit) begin
                c_d.st     = PH_SEND;
                c_d.done   = 1'b1;
                c_d.res    = decided;
                c_d.res_ch = c_q.ch;
            end
            PH_SEND: if (!tx_active) c_d.st = PH_IDLE;
            default: c_d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.st  <= PH_IDLE;
            c_q.ptr <= CH_W'(NUM_CH - 1);
        end else begin
            c_q <= c_d;
        end
    end

    assign mux_sel   = c_q.ch;
    assign sample    = (c_q.st == PH_SAMP);
    assign dac_code  = step ? trial : '0;
    assign busy      = (c_q.st != PH_IDLE);
    assign done      = c_q.done;
    assign result    = c_q.res;
    assign result_ch = c_q.res_ch;

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_frame_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_cs_n |-> busy);
    p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st != PH_IDLE) |=> $stable(c_q.ch));
    p_pick_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !single_mode) |-> ch_mask[pick]);
    p_single_keeps_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && single_mode) |=> $stable(c_q.ptr));
    p_empty_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !single_mode && ch_mask == '0) |=> !busy);
endmodule

// File: tb/sar_scan_ctrl_tb.sv
`timescale 1ns/1ps
module sar_scan_ctrl_tb_top;
    localparam int N  = 12;
    localparam int NC = 8;
    localparam int CW = 3;
    localparam int F  = CW + N;
    localparam int FULL = (1 << N) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          single_mode = 1'b1;
    logic [CW-1:0] single_ch = '0;
    logic [NC-1:0] ch_mask = '0;
    logic          cmp_hi;
    logic [CW-1:0] mux_sel;
    logic          sample;
    logic [N-1:0]  dac_code;
    logic          busy, done;
    logic [N-1:0]  result;
    logic [CW-1:0] result_ch;
    logic          ser_cs_n, ser_sck, ser_sdo;

    int vin [NC];
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    assign cmp_hi = (vin[mux_sel] >= int'(dac_code));

    sar_scan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .single_mode(single_mode),
        .single_ch(single_ch), .ch_mask(ch_mask), .cmp_hi(cmp_hi),
        .mux_sel(mux_sel), .sample(sample), .dac_code(dac_code), .busy(busy),
        .done(done), .result(result), .result_ch(result_ch),
        .ser_cs_n(ser_cs_n), .ser_sck(ser_sck), .ser_sdo(ser_sdo)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference timeline model
    int ph = 0, m_ch = 0, m_v = 0, m_ptr = NC - 1, m_res = 0, m_resch = 0;

    function automatic int next_scan(logic [NC-1:0] msk, int last);
        for (int i = last + 1; i < NC; i++) if (msk[i]) return i;
        for (int i = 0; i < NC; i++) if (msk[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_ptr = NC - 1; m_res = 0; m_resch = 0;
        end else if (ph == 0) begin
            if (start) begin
                int c;
                c = single_mode ? int'(single_ch) : next_scan(ch_mask, m_ptr);
                if (c >= 0) begin
                    if (!single_mode) m_ptr = c;
                    m_ch = c;
                    m_v  = (vin[c] > FULL) ? FULL : vin[c];
                    ph   = 1;
                end
            end
        end else begin
            ph++;
            if (ph == N + 2) begin m_res = m_v; m_resch = m_ch; end
            if (ph == N + 3 + 2 * F) ph = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int e_dac, q, word, b;
            bit frame;
            e_dac = 0;
            if (ph >= 2 && ph <= N + 1) begin
                b = N - 1 - (ph - 2);
                e_dac = ((m_v >> (b + 1)) << (b + 1)) | (1 << b);
            end
            frame = (ph >= N + 2) && (ph <= N + 1 + 2 * F);
            q = ph - (N + 2);
            word = (m_ch << N) | m_v;
            chk("R7", "busy", int'(busy), int'(ph != 0));
            chk("R3", "sample", int'(sample), int'(ph == 1));
            if (ph == 1) chk("R4/R5", "mux_sel", int'(mux_sel), m_ch);
            chk("R1", "dac_code", int'(dac_code), e_dac);
            chk("R3", "done", int'(done), int'(ph == N + 2));
            chk("R2", "result", int'(result), m_res);
            chk("R3", "result_ch", int'(result_ch), m_resch);
            chk("R6", "ser_cs_n", int'(ser_cs_n), int'(!frame));
            chk("R6", "ser_sck", int'(ser_sck), frame ? (q % 2) : 0);
            chk("R6", "ser_sdo", int'(ser_sdo), frame ? ((word >> (F - 1 - q / 2)) & 1) : 0);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic convert(bit sm, int ch, int exp_ch, int exp_v, string req, bit poke);
        single_mode = sm;
        single_ch   = CW'(ch);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            cycles(5);
            single_mode = 1'b1;
            single_ch   = CW'((ch + 3) % NC);
            start       = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 200 && !done; k++) @(negedge clk);
        chk(req, "done seen", int'(done), 1);
        chk(req, "result_ch", int'(result_ch), exp_ch);
        chk("R2", "result", int'(result), exp_v);
        for (int k = 0; k < 200 && busy; k++) @(negedge clk);
        cycles(2);
        if (poke) chk("R7", "no restart after ignored start", int'(busy), 0);
    endtask

    initial begin
        vin = '{100, 4095, 0, 2730, 1, 5000, 2048, 2047};
        cycles(3);
        chk("R9", "busy", int'(busy), 0);
        chk("R9", "ser_cs_n", int'(ser_cs_n), 1);
        chk("R9", "ser_sck", int'(ser_sck), 0);
        chk("R9", "ser_sdo", int'(ser_sdo), 0);
        chk("R9", "done", int'(done), 0);
        chk("R9", "sample", int'(sample), 0);
        chk("R9", "dac_code", int'(dac_code), 0);
        chk("R9", "result", int'(result), 0);
        chk("R9", "result_ch", int'(result_ch), 0);
        rst_n = 1'b1;
        cycles(2);

        convert(1'b1, 2, 2, 0,    "R2", 1'b0);
        convert(1'b1, 1, 1, 4095, "R2", 1'b0);
        convert(1'b1, 3, 3, 2730, "R2", 1'b0);
        convert(1'b1, 5, 5, 4095, "R2", 1'b0);
        convert(1'b1, 4, 4, 1,    "R2", 1'b0);

        ch_mask = 8'b1010_0100;
        convert(1'b0, 0, 2, 0,    "R4", 1'b0);
        convert(1'b1, 6, 6, 2048, "R5", 1'b0);
        convert(1'b0, 0, 5, 4095, "R5", 1'b0);
        convert(1'b0, 0, 7, 2047, "R4", 1'b0);
        convert(1'b0, 0, 2, 0,    "R4", 1'b0);

        convert(1'b1, 7, 7, 2047, "R7", 1'b1);

        ch_mask = 8'b0000_1000;
        convert(1'b0, 0, 3, 2730, "R4", 1'b0);
        convert(1'b0, 0, 3, 2730, "R4", 1'b0);

        ch_mask = '0;
        single_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "busy after empty-mask start", int'(busy), 0);
        cycles(3);
        chk("R8", "still idle", int'(busy), 0);
        chk("R8", "result_ch unchanged", int'(result_ch), 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule